// File: doc/BRIEF.md
# UART Channel Prioritized Interrupt Controller

This block sits beside one UART channel. It holds the channel's 8-bit interrupt enable register. It gathers the channel's status events into pending sources and drives a single interrupt line. It also drives a 6-bit identification code that names the most urgent pending source. The serial engine, the FIFOs and the flow-control logic sit outside the block. They feed it level and pulse status signals, and they send one service pulse per source when software has dealt with that source.

There are seven sources: line error, receive data, transmit ready, modem change, Xoff received, RTS rising and CTS rising. The receive and transmit sources take their level from either the holding-register signal or the FIFO-trigger signal, chosen by the FIFO-enable input. The four upper enable bits belong to enhanced features. They can be written, and they have effect, only while the enhanced-feature input is high. Event sources are captured only while their enable is effective. Once captured, they stay pending until their own service pulse arrives.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, ierQ reads 0x00, irq is 0 and intId is 0x01.
- R2: An enable write always loads bits 3:0 from ierWrData. It loads bits 7:4 only when enhEn is 1; otherwise they keep their old value. The bit map is: 0 receive data, 1 transmit ready, 2 line error, 3 modem change, 4 sleep (stored only), 5 Xoff, 6 RTS, 7 CTS.
- R3: Enable bits 7:4 count only while enhEn is 1. Dropping enhEn masks pending Xoff, RTS and CTS sources. Raising enhEn again shows them once more.
- R4: The receive-data source follows rxTrig when fifoEn is 1 and rxHold when fifoEn is 0. It is pending in the cycle after its level is seen high and clears in the cycle after the level is seen low.
- R5: The transmit level is txBelowTrig when fifoEn is 1 and thrEmpty when fifoEn is 0. A rising edge of this level, while enable bit 1 is set, makes transmit-ready pending. The source clears on txSvc or when the level goes low.
- R6: A write that sets enable bit 1 while it was clear and the transmit level is high makes transmit-ready pending at once, with no edge needed.
- R7: A lineErrEvt pulse makes line error pending, and lineSvc clears it. A modemEvt pulse makes modem change pending, and modemSvc clears it.
- R8: An xoffEvt pulse makes Xoff pending, and xoffSvc clears it.
- R9: A low-to-high transition on rtsPin makes the RTS source pending, and the same holds for ctsPin and CTS. The source stays pending after the pin falls, until rtsSvc or ctsSvc clears it.
- R10: intId names the highest-priority pending source whose enable is effective. The order and codes, highest first, are: line error 0x06, receive data 0x04, transmit ready 0x02, modem change 0x00, Xoff 0x10, RTS or CTS 0x20. The code is 0x01 when nothing is pending. irq is 1 exactly when some source is reported.
- R11: When a source's event and its service pulse arrive in the same cycle, the source remains pending.
- R12: With all enable bits at 0, irq stays 0 and intId reads 0x01 whatever the status inputs do.
- R13: An event pulse or pin edge that arrives while its enable is not effective is discarded. Enabling the source later raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ierWrEn | input | 1 | Enable register write strobe |
| ierWrData | input | 8 | Enable register write value |
| enhEn | input | 1 | Enhanced-feature enable |
| fifoEn | input | 1 | FIFO mode select |
| rxHold | input | 1 | Receive holding register has a character |
| rxTrig | input | 1 | Receive FIFO at trigger level |
| thrEmpty | input | 1 | Transmit holding register empty |
| txBelowTrig | input | 1 | Transmit FIFO below trigger level |
| lineErrEvt | input | 1 | Pulse: character arrived with an error flag |
| modemEvt | input | 1 | Pulse: modem status changed |
| xoffEvt | input | 1 | Pulse: Xoff character received |
| rtsPin | input | 1 | RTS pin level |
| ctsPin | input | 1 | CTS pin level |
| lineSvc | input | 1 | Service pulse for line error |
| modemSvc | input | 1 | Service pulse for modem change |
| xoffSvc | input | 1 | Service pulse for Xoff |
| rtsSvc | input | 1 | Service pulse for RTS |
| ctsSvc | input | 1 | Service pulse for CTS |
| txSvc | input | 1 | Service pulse for transmit ready |
| ierQ | output | 8 | Enable register contents |
| irq | output | 1 | Interrupt request |
| intId | output | 6 | Identification code of the highest pending source |

## Verification
Two things can meet in one clock edge. First, a source's new event can arrive together with its own service pulse. Second, an enable write that turns on transmit-ready can arrive while the transmit level is already high. The bench drives an Xoff pulse and an Xoff service pulse in the same cycle, and does the same for the CTS rising edge and its service pulse; it then expects the source still reported. It also writes enable bit 1 with the holding register long empty and expects code 0x02 one edge later. Every combination of the seven sources is raised together. Each is then retired, highest priority first, and after each step the code is compared with the next source the priority order predicts.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IER_W = 8;
  localparam int ID_W = 6;
  localparam int NUM_SRC = 7;

  // Source indices, highest priority first.
  localparam int SRC_LINE = 0;
  localparam int SRC_RX = 1;
  localparam int SRC_TX = 2;
  localparam int SRC_MODEM = 3;
  localparam int SRC_XOFF = 4;
  localparam int SRC_RTS = 5;
  localparam int SRC_CTS = 6;

  localparam logic [ID_W-1:0] CODE_NONE = 6'h01;
  localparam logic [ID_W-1:0] CODE_LINE = 6'h06;
  localparam logic [ID_W-1:0] CODE_RX = 6'h04;
  localparam logic [ID_W-1:0] CODE_TX = 6'h02;
  localparam logic [ID_W-1:0] CODE_MODEM = 6'h00;
  localparam logic [ID_W-1:0] CODE_XOFF = 6'h10;
  localparam logic [ID_W-1:0] CODE_PIN = 6'h20;

  typedef struct packed {
    logic ierLoadLow;
    logic ierLoadHigh;
    logic evLine;
    logic evModem;
    logic evXoff;
    logic evRts;
    logic evCts;
    logic armTx;
    logic svcLine;
    logic svcModem;
    logic svcXoff;
    logic svcRts;
    logic svcCts;
    logic clrTx;
    logic rxLevel;
  } irqStrobe_t;

  function automatic logic [ID_W-1:0] srcCode(input int idx);
    case (idx)
      SRC_LINE:  return CODE_LINE;
      SRC_RX:    return CODE_RX;
      SRC_TX:    return CODE_TX;
      SRC_MODEM: return CODE_MODEM;
      SRC_XOFF:  return CODE_XOFF;
      default:   return CODE_PIN;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_strobes.sv
module uart_irq_strobes
  import uart_irq_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic ierWrEn,
  input  logic wrTxEnable,
  input  logic txEnabled,
  input  logic enhEn,
  input  logic fifoEn,
  input  logic rxHold,
  input  logic rxTrig,
  input  logic thrEmpty,
  input  logic txBelowTrig,
  input  logic lineErrEvt,
  input  logic modemEvt,
  input  logic xoffEvt,
  input  logic rtsPin,
  input  logic ctsPin,
  input  logic lineSvc,
  input  logic modemSvc,
  input  logic xoffSvc,
  input  logic rtsSvc,
  input  logic ctsSvc,
  input  logic txSvc,
  output irqStrobe_t strb
);
  logic txLevel;
  logic txPrev;
  logic rtsPrev;
  logic ctsPrev;

  assign txLevel = fifoEn ? txBelowTrig : thrEmpty;

  // Previous levels for edge detection; pins start high so reset release makes no edge.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPrev <= 1'b0;
      rtsPrev <= 1'b1;
      ctsPrev <= 1'b1;
    end else begin
      txPrev <= txLevel;
      rtsPrev <= rtsPin;
      ctsPrev <= ctsPin;
    end
  end

  always_comb begin
    strb = '0;
    strb.ierLoadLow = ierWrEn;
    strb.ierLoadHigh = ierWrEn & enhEn;
    strb.evLine = lineErrEvt;
    strb.evModem = modemEvt;
    strb.evXoff = xoffEvt;
    strb.evRts = rtsPin & ~rtsPrev;
    strb.evCts = ctsPin & ~ctsPrev;
    strb.armTx = txLevel & ((~txPrev & txEnabled) | (ierWrEn & wrTxEnable & ~txEnabled));
    strb.svcLine = lineSvc;
    strb.svcModem = modemSvc;
    strb.svcXoff = xoffSvc;
    strb.svcRts = rtsSvc;
    strb.svcCts = ctsSvc;
    strb.clrTx = txSvc | ~txLevel;
    strb.rxLevel = fifoEn ? rxTrig : rxHold;
  end
endmodule

// File: rtl/uart_irq_core.sv
module uart_irq_core
  import uart_irq_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  irqStrobe_t strb,
  input  logic [IER_W-1:0] ierWrData,
  input  logic enhEn,
  output logic [IER_W-1:0] ierQ,
  output logic irq,
  output logic [ID_W-1:0] intId
);
  localparam int LOW_W = IER_W / 2;

  logic [IER_W-1:0] ierReg;
  logic [NUM_SRC-1:0] enMask;
  logic [NUM_SRC-1:0] setVec;
  logic [NUM_SRC-1:0] clrVec;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] active;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ierReg <= '0;
    end else if (strb.ierLoadLow) begin
      ierReg[LOW_W-1:0] <= ierWrData[LOW_W-1:0];
      if (strb.ierLoadHigh) ierReg[IER_W-1:LOW_W] <= ierWrData[IER_W-1:LOW_W];
    end
  end

  assign ierQ = ierReg;

  // Effective enables per source index; upper bits depend on enhEn.
  assign enMask = {ierReg[7] & enhEn, ierReg[6] & enhEn, ierReg[5] & enhEn,
                   ierReg[3], ierReg[1], ierReg[0], ierReg[2]};

  assign setVec = {strb.evCts & enMask[SRC_CTS], strb.evRts & enMask[SRC_RTS],
                   strb.evXoff & enMask[SRC_XOFF], strb.evModem & enMask[SRC_MODEM],
                   strb.armTx, strb.rxLevel, strb.evLine & enMask[SRC_LINE]};
  assign clrVec = {strb.svcCts, strb.svcRts, strb.svcXoff, strb.svcModem,
                   strb.clrTx, ~strb.rxLevel, strb.svcLine};

  for (genvar i = 0; i < NUM_SRC; i++) begin : gPend
    always_ff @(posedge clk) begin
      if (!rstN) pend[i] <= 1'b0;
      else if (setVec[i]) pend[i] <= 1'b1;
      else if (clrVec[i]) pend[i] <= 1'b0;
    end
  end

  assign active = pend & enMask;
  assign irq = |active;

  always_comb begin
    intId = CODE_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (active[i]) intId = srcCode(i);
    end
  end

  assert_upper_guard_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.ierLoadLow && !strb.ierLoadHigh |=> ierQ[IER_W-1:LOW_W] == $past(ierQ[IER_W-1:LOW_W]));

  assert_line_first_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.evLine && enMask[SRC_LINE] && !strb.ierLoadLow |=> irq && intId == CODE_LINE);

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.evXoff && enMask[SRC_XOFF] |=> pend[SRC_XOFF]);

  assert_pin_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    pend[SRC_CTS] && !strb.svcCts && !strb.evCts |=> pend[SRC_CTS]);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic ierWrEn,
  input  logic [IER_W-1:0] ierWrData,
  input  logic enhEn,
  input  logic fifoEn,
  input  logic rxHold,
  input  logic rxTrig,
  input  logic thrEmpty,
  input  logic txBelowTrig,
  input  logic lineErrEvt,
  input  logic modemEvt,
  input  logic xoffEvt,
  input  logic rtsPin,
  input  logic ctsPin,
  input  logic lineSvc,
  input  logic modemSvc,
  input  logic xoffSvc,
  input  logic rtsSvc,
  input  logic ctsSvc,
  input  logic txSvc,
  output logic [IER_W-1:0] ierQ,
  output logic irq,
  output logic [ID_W-1:0] intId
);
  irqStrobe_t strb;

  uart_irq_strobes uStrobes (
    .clk(clk), .rstN(rstN), .ierWrEn(ierWrEn), .wrTxEnable(ierWrData[1]),
    .txEnabled(ierQ[1]), .enhEn(enhEn), .fifoEn(fifoEn), .rxHold(rxHold),
    .rxTrig(rxTrig), .thrEmpty(thrEmpty), .txBelowTrig(txBelowTrig),
    .lineErrEvt(lineErrEvt), .modemEvt(modemEvt), .xoffEvt(xoffEvt),
    .rtsPin(rtsPin), .ctsPin(ctsPin), .lineSvc(lineSvc), .modemSvc(modemSvc),
    .xoffSvc(xoffSvc), .rtsSvc(rtsSvc), .ctsSvc(ctsSvc), .txSvc(txSvc),
    .strb(strb)
  );

  uart_irq_core uCore (
    .clk(clk), .rstN(rstN), .strb(strb), .ierWrData(ierWrData), .enhEn(enhEn),
    .ierQ(ierQ), .irq(irq), .intId(intId)
  );

  assert_tx_immediate_R6: assert property (@(posedge clk) disable iff (!rstN)
    ierWrEn && ierWrData[1] && !ierQ[1] && (fifoEn ? txBelowTrig : thrEmpty) |=> irq);

  assert_polled_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    ierQ == '0 |-> !irq && intId == CODE_NONE);

  assert_idle_code_R10: assert property (@(posedge clk) disable iff (!rstN)
    !irq |-> intId == CODE_NONE);
endmodule

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ierWrEn = 0, enhEn = 0, fifoEn = 0;
  logic [7:0] ierWrData = 0;
  logic rxHold = 0, rxTrig = 0, thrEmpty = 0, txBelowTrig = 0;
  logic lineErrEvt = 0, modemEvt = 0, xoffEvt = 0, rtsPin = 0, ctsPin = 0;
  logic lineSvc = 0, modemSvc = 0, xoffSvc = 0, rtsSvc = 0, ctsSvc = 0, txSvc = 0;
  logic [7:0] ierQ;
  logic irq;
  logic [5:0] intId;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .ierWrEn(ierWrEn), .ierWrData(ierWrData), .enhEn(enhEn),
    .fifoEn(fifoEn), .rxHold(rxHold), .rxTrig(rxTrig), .thrEmpty(thrEmpty),
    .txBelowTrig(txBelowTrig), .lineErrEvt(lineErrEvt), .modemEvt(modemEvt),
    .xoffEvt(xoffEvt), .rtsPin(rtsPin), .ctsPin(ctsPin), .lineSvc(lineSvc),
    .modemSvc(modemSvc), .xoffSvc(xoffSvc), .rtsSvc(rtsSvc), .ctsSvc(ctsSvc),
    .txSvc(txSvc), .ierQ(ierQ), .irq(irq), .intId(intId)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic checkId(input string tag, input logic [5:0] exp);
    check(tag, {2'b0, intId}, {2'b0, exp});
    check(tag, {7'b0, irq}, {7'b0, exp != 6'h01});
  endtask

  task automatic wrIer(input logic [7:0] v);
    ierWrEn = 1; ierWrData = v;
    tick();
    ierWrEn = 0;
  endtask

  task automatic dropPulses();
    lineErrEvt = 0; modemEvt = 0; xoffEvt = 0;
    lineSvc = 0; modemSvc = 0; xoffSvc = 0; rtsSvc = 0; ctsSvc = 0; txSvc = 0;
  endtask

  task automatic svcAll();
    lineSvc = 1; modemSvc = 1; xoffSvc = 1; rtsSvc = 1; ctsSvc = 1; txSvc = 1;
    tick();
    dropPulses();
  endtask

  // Priority order: 0 line, 1 rx, 2 tx, 3 modem, 4 xoff, 5 rts, 6 cts.
  function automatic logic [5:0] expCode(input logic [6:0] m);
    for (int i = 0; i < 7; i++) begin
      if (m[i]) begin
        case (i)
          0: return 6'h06;
          1: return 6'h04;
          2: return 6'h02;
          3: return 6'h00;
          4: return 6'h10;
          default: return 6'h20;
        endcase
      end
    end
    return 6'h01;
  endfunction

  task automatic serviceOne(input int idx);
    case (idx)
      0: lineSvc = 1;
      1: rxHold = 0;
      2: txSvc = 1;
      3: modemSvc = 1;
      4: xoffSvc = 1;
      5: rtsSvc = 1;
      default: ctsSvc = 1;
    endcase
    tick();
    dropPulses();
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    logic [6:0] rem;
    tick();
    tick();
    // R1 reset state
    check("R1 ierQ", ierQ, 8'h00);
    checkId("R1 id", 6'h01);
    rstN = 1;
    tick();
    checkId("R1 after release", 6'h01);

    // R12 polled: all enables 0, drive everything
    rxHold = 1; thrEmpty = 1; lineErrEvt = 1; modemEvt = 1; xoffEvt = 1; rtsPin = 1; ctsPin = 1;
    enhEn = 1;
    tick();
    dropPulses();
    tick();
    checkId("R12 polled quiet", 6'h01);
    rxHold = 0; thrEmpty = 0; rtsPin = 0; ctsPin = 0;
    tick();

    // R2 upper bits guarded by enhEn
    enhEn = 0;
    wrIer(8'hA5);
    check("R2 guarded write", ierQ, 8'h05);
    enhEn = 1;
    wrIer(8'hA5);
    check("R2 enhanced write", ierQ, 8'hA5);
    enhEn = 0;
    wrIer(8'h00);
    check("R2 low clear keeps upper", ierQ, 8'hA0);
    enhEn = 1;
    wrIer(8'h00);

    // R13 event while disabled is dropped
    modemEvt = 1; tick(); dropPulses();
    wrIer(8'h08);
    checkId("R13 modem dropped", 6'h01);
    rtsPin = 1; tick();
    wrIer(8'h48);
    checkId("R13 rts dropped", 6'h01);
    rtsPin = 0; tick();

    // R7 modem and line
    modemEvt = 1; tick(); dropPulses();
    checkId("R7 modem pending", 6'h00);
    wrIer(8'h4C);
    lineErrEvt = 1; tick(); dropPulses();
    checkId("R7 line over modem", 6'h06);
    serviceOne(0);
    checkId("R7 line serviced", 6'h00);
    serviceOne(3);
    checkId("R7 modem serviced", 6'h01);

    // R9 and R3 pin latch held after fall, masked by enhEn
    rtsPin = 1; tick(); rtsPin = 0; tick(); tick();
    checkId("R9 rts held after fall", 6'h20);
    enhEn = 0; tick();
    checkId("R3 masked without enhEn", 6'h01);
    check("R3 ierQ kept", ierQ, 8'h4C);
    enhEn = 1; tick();
    checkId("R3 shown again", 6'h20);
    serviceOne(5);
    checkId("R9 rts serviced", 6'h01);

    // R8 and R11 Xoff set and service same cycle
    wrIer(8'hFF);
    xoffEvt = 1; tick(); dropPulses();
    checkId("R8 xoff pending", 6'h10);
    xoffEvt = 1; xoffSvc = 1; tick(); dropPulses();
    checkId("R11 xoff set wins", 6'h10);
    serviceOne(4);
    checkId("R8 xoff serviced", 6'h01);
    ctsPin = 1; ctsSvc = 1; tick(); dropPulses();
    checkId("R11 cts edge wins", 6'h20);
    ctsPin = 0; serviceOne(6);
    checkId("R9 cts serviced", 6'h01);

    // R6 immediate tx on enable write
    wrIer(8'hF0);
    thrEmpty = 1; tick(); tick();
    checkId("R6 before enable", 6'h01);
    wrIer(8'hF2);
    checkId("R6 immediate", 6'h02);
    serviceOne(2);
    checkId("R5 txSvc clears", 6'h01);
    thrEmpty = 0; tick();

    // R5 FIFO mode transmit level
    fifoEn = 1;
    txBelowTrig = 1; tick();
    checkId("R5 fifo tx rise", 6'h02);
    thrEmpty = 1; txBelowTrig = 0; tick();
    checkId("R5 fifo tx fall clears", 6'h01);
    thrEmpty = 0;

    // R4 receive level source select
    wrIer(8'hF1);
    rxHold = 1; tick();
    checkId("R4 fifo ignores rxHold", 6'h01);
    rxTrig = 1; tick();
    checkId("R4 fifo rxTrig", 6'h04);
    fifoEn = 0; rxTrig = 1; rxHold = 0; tick();
    checkId("R4 non-fifo follows rxHold", 6'h01);
    rxHold = 1; tick();
    checkId("R4 non-fifo rxHold", 6'h04);
    rxHold = 0; rxTrig = 0; tick();
    checkId("R4 clears", 6'h01);

    // R10 sweep of all source combinations, retired highest first
    wrIer(8'hFF);
    for (int m = 0; m < 128; m++) begin
      svcAll();
      lineErrEvt = m[0]; rxHold = m[1]; thrEmpty = m[2]; modemEvt = m[3];
      xoffEvt = m[4]; rtsPin = m[5]; ctsPin = m[6];
      tick();
      dropPulses();
      rem = 7'(m);
      checkId($sformatf("R10 mask %0d", m), expCode(rem));
      for (int k = 0; k < 7; k++) begin
        if (rem[k]) begin
          serviceOne(k);
          rem[k] = 1'b0;
          checkId($sformatf("R10 mask %0d after src %0d", m, k), expCode(rem));
        end
      end
      rxHold = 0; thrEmpty = 0; rtsPin = 0; ctsPin = 0;
      tick();
    end

    done = 1;
    finishRun();
  end
endmodule